// File: doc/BRIEF.md
# Fixed-Rate Control Loop Sequencer

This block runs a closed control loop at a fixed rate with no host software in the sample path. A programmable period timer produces step triggers. On each accepted trigger, the block hands the most recent converter samples to an external arithmetic engine and starts that engine. When the engine reports completion, the block loads both converter output registers in the same clock edge. The converter inputs and outputs are double-registered: a new sample can arrive while the engine works on the previous one, and a new result can be prepared while the current output is still driven.

A small memory-mapped register port configures the loop. It holds the run enable, the timer period, a requested coefficient bank and a status word. It also exposes a window of coefficient storage, which only the host can write, and a window of engine state, which the host can read. A bank request is applied only when a step starts, so a single step never mixes two coefficient sets. A host write to a trigger register starts a step immediately, whatever the timer is doing. If a trigger arrives while the engine is still busy, the trigger is dropped and a sticky overrun flag is set.

Top module: `loop_seq`

## Requirements
- R1: After reset, both converter outputs, both engine inputs, `engStart`, the enable, the requested bank, the active bank, and the busy and overrun flags are all 0. The period register (address 0x01) reads 16.
- R2: While the enable bit (bit 0 of address 0x00) is 1 and the block is idle, the timer triggers a step every P cycles, where P is the value at address 0x01. P values of 0 and 1 both trigger every cycle.
- R3: When a step is accepted, both engine inputs take the sample values held before that edge, and `engStart` is high for exactly the next cycle. A sample strobe in the same cycle updates only the input holding register.
- R4: When `engDone` is high while busy, both converter outputs load `engOut0` and `engOut1` on the same edge, and busy (status bit 0) clears.
- R5: `engDone` while idle has no effect: both converter outputs keep their values.
- R6: A trigger while busy starts no step and sets the sticky overrun flag (status bit 1). Any host write to address 0x03 clears the flag, unless a new overrun occurs in the same cycle.
- R7: The bank written at address 0x02 becomes active only when the next step is accepted. The active bank appears on `engBank` and in status bits [4 +: bank width].
- R8: Coefficient entry k sits at host address 0x40+k and is host-writable only. `engCoefData` returns entry (active bank × 8 + `engCoefIdx`).
- R9: State entry i, written by the engine through the state write port, reads back at host address 0x20+i.
- R10: A host write to address 0x04 triggers a step at once, whether or not the timer is enabled.
- R11: Clearing the enable bit stops timer triggers and restarts the timer phase, so the first trigger after re-enabling comes P cycles after the enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adcValid | input | 1 | New sample strobe for both input channels |
| adc0In | input | 16 | Channel 0 input sample |
| adc1In | input | 16 | Channel 1 input sample |
| dac0Out | output | 16 | Channel 0 converter output |
| dac1Out | output | 16 | Channel 1 converter output |
| engStart | output | 1 | One-cycle step start to the engine |
| engIn0 | output | 16 | Engine-side channel 0 sample |
| engIn1 | output | 16 | Engine-side channel 1 sample |
| engBank | output | 1 | Coefficient bank in use for this step |
| engCoefIdx | input | 3 | Engine coefficient read index |
| engCoefData | output | 16 | Coefficient at active bank and index |
| engDone | input | 1 | Engine completion pulse |
| engOut0 | input | 16 | Engine result, channel 0 |
| engOut1 | input | 16 | Engine result, channel 1 |
| engStateWe | input | 1 | Engine state write enable |
| engStateIdx | input | 3 | Engine state write index |
| engStateData | input | 16 | Engine state write data |
| hostWe | input | 1 | Host register write strobe |
| hostAddr | input | 8 | Host register address |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data for hostAddr |

## Verification
The loop is driven with a long period and a short engine latency, so every trigger is accepted. It is then driven with a period shorter than the engine latency, which separates accepted steps from dropped triggers and overrun. A period of zero checks the every-cycle limit. Runs with the timer disabled, host trigger writes and spurious completions show that steps start only from the two allowed sources and that outputs move only on a real completion. The input strobe skips every third cycle, so the test shows whether the engine receives the value held before the trigger edge or a later one. Bank requests made while running and while stopped show whether a bank change can take effect in the middle of a step.

// File: rtl/loop_seq_pkg.sv
package loop_seq_pkg;
  localparam int HOST_AW = 8;
  localparam int ADDR_CTRL   = 8'h00;
  localparam int ADDR_PERIOD = 8'h01;
  localparam int ADDR_BANK   = 8'h02;
  localparam int ADDR_STATUS = 8'h03;
  localparam int ADDR_KICK   = 8'h04;
  localparam int STATE_BASE  = 8'h20;
  localparam int COEF_BASE   = 8'h40;
  localparam int STAT_BANK_LSB = 4;

  typedef struct packed {
    logic accept;   // step accepted: move samples to engine side
    logic publish;  // engine finished: move results to converter side
  } seqStrobe_t;
endpackage

// File: rtl/loop_seq_ctrl.sv
module loop_seq_ctrl
  import loop_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 16,
  parameter int BW = 1,
  parameter int RST_PERIOD = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hostWe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DW-1:0]      hostWdata,
  input  logic               engDone,
  output seqStrobe_t         strobe,
  output logic               enable,
  output logic [PW-1:0]      period,
  output logic [BW-1:0]      pendBank,
  output logic [BW-1:0]      activeBank,
  output logic               busy,
  output logic               overrun,
  output logic               engStart
);
  logic [PW-1:0] tickCnt;
  logic timerTick, hostKick, trig, ovrSet, statWr;

  assign timerTick = enable && (({1'b0, tickCnt} + 1'b1) >= {1'b0, period});
  assign hostKick  = hostWe && (int'(hostAddr) == ADDR_KICK);
  assign statWr    = hostWe && (int'(hostAddr) == ADDR_STATUS);
  assign trig      = timerTick || hostKick;
  assign ovrSet    = trig && busy;
  assign strobe.accept  = trig && !busy;
  assign strobe.publish = engDone && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable   <= 1'b0;
      period   <= PW'(RST_PERIOD);
      pendBank <= '0;
    end else if (hostWe) begin
      if (int'(hostAddr) == ADDR_CTRL)   enable   <= hostWdata[0];
      if (int'(hostAddr) == ADDR_PERIOD) period   <= hostWdata[PW-1:0];
      if (int'(hostAddr) == ADDR_BANK)   pendBank <= hostWdata[BW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         tickCnt <= '0;
    else if (!enable)   tickCnt <= '0;
    else if (timerTick) tickCnt <= '0;
    else                tickCnt <= tickCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      overrun    <= 1'b0;
      engStart   <= 1'b0;
      activeBank <= '0;
    end else begin
      engStart <= strobe.accept;
      if (strobe.accept) begin
        busy       <= 1'b1;
        activeBank <= pendBank;
      end else if (strobe.publish) begin
        busy <= 1'b0;
      end
      if (ovrSet)      overrun <= 1'b1;
      else if (statWr) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/loop_seq_dpath.sv
module loop_seq_dpath
  import loop_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 16,
  parameter int BW = 1,
  parameter int NCH = 2,
  parameter int NBANK = 2,
  parameter int NCOEF = 8,
  parameter int NSTATE = 8,
  localparam int CIW = $clog2(NCOEF),
  localparam int SIW = $clog2(NSTATE),
  localparam int NCE = NBANK * NCOEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  seqStrobe_t         strobe,
  input  logic               adcValid,
  input  logic [NCH*DW-1:0]  adcFlat,
  input  logic [NCH*DW-1:0]  resFlat,
  output logic [NCH*DW-1:0]  engInFlat,
  output logic [NCH*DW-1:0]  dacFlat,
  input  logic [BW-1:0]      activeBank,
  input  logic [CIW-1:0]     engCoefIdx,
  output logic [DW-1:0]      engCoefData,
  input  logic               engStateWe,
  input  logic [SIW-1:0]     engStateIdx,
  input  logic [DW-1:0]      engStateData,
  input  logic               hostWe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DW-1:0]      hostWdata,
  input  logic               enable,
  input  logic [PW-1:0]      period,
  input  logic [BW-1:0]      pendBank,
  input  logic               busy,
  input  logic               overrun,
  output logic [DW-1:0]      hostRdata
);
  logic [DW-1:0] coefMem  [NCE];
  logic [DW-1:0] stateMem [NSTATE];

  // One shadowed pair per converter channel on each side
  for (genvar g = 0; g < NCH; g++) begin : gChan
    logic [DW-1:0] shadowQ, engQ, dacQ;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadowQ <= '0;
        engQ    <= '0;
        dacQ    <= '0;
      end else begin
        if (adcValid)       shadowQ <= adcFlat[g*DW +: DW];
        if (strobe.accept)  engQ    <= shadowQ;
        if (strobe.publish) dacQ    <= resFlat[g*DW +: DW];
      end
    end
    assign engInFlat[g*DW +: DW] = engQ;
    assign dacFlat[g*DW +: DW]   = dacQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NCE; k++) coefMem[k] <= '0;
    end else if (hostWe) begin
      for (int k = 0; k < NCE; k++)
        if (int'(hostAddr) == COEF_BASE + k) coefMem[k] <= hostWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NSTATE; k++) stateMem[k] <= '0;
    end else if (engStateWe) begin
      for (int k = 0; k < NSTATE; k++)
        if (int'(engStateIdx) == k) stateMem[k] <= engStateData;
    end
  end

  always_comb begin
    engCoefData = '0;
    for (int k = 0; k < NCE; k++)
      if (k == int'(activeBank) * NCOEF + int'(engCoefIdx)) engCoefData = coefMem[k];
  end

  always_comb begin
    hostRdata = '0;
    case (int'(hostAddr))
      ADDR_CTRL:   hostRdata[0] = enable;
      ADDR_PERIOD: hostRdata[PW-1:0] = period;
      ADDR_BANK:   hostRdata[BW-1:0] = pendBank;
      ADDR_STATUS: begin
        hostRdata[0] = busy;
        hostRdata[1] = overrun;
        hostRdata[STAT_BANK_LSB +: BW] = activeBank;
      end
      default: ;
    endcase
    for (int k = 0; k < NSTATE; k++)
      if (int'(hostAddr) == STATE_BASE + k) hostRdata = stateMem[k];
    for (int k = 0; k < NCE; k++)
      if (int'(hostAddr) == COEF_BASE + k) hostRdata = coefMem[k];
  end
endmodule

// File: rtl/loop_seq.sv
module loop_seq
  import loop_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 16,
  parameter int NBANK = 2,
  parameter int NCOEF = 8,
  parameter int NSTATE = 8,
  parameter int RST_PERIOD = 16,
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int CIW = $clog2(NCOEF),
  localparam int SIW = $clog2(NSTATE)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adcValid,
  input  logic [DW-1:0]  adc0In,
  input  logic [DW-1:0]  adc1In,
  output logic [DW-1:0]  dac0Out,
  output logic [DW-1:0]  dac1Out,
  output logic           engStart,
  output logic [DW-1:0]  engIn0,
  output logic [DW-1:0]  engIn1,
  output logic [BW-1:0]  engBank,
  input  logic [CIW-1:0] engCoefIdx,
  output logic [DW-1:0]  engCoefData,
  input  logic           engDone,
  input  logic [DW-1:0]  engOut0,
  input  logic [DW-1:0]  engOut1,
  input  logic           engStateWe,
  input  logic [SIW-1:0] engStateIdx,
  input  logic [DW-1:0]  engStateData,
  input  logic           hostWe,
  input  logic [7:0]     hostAddr,
  input  logic [DW-1:0]  hostWdata,
  output logic [DW-1:0]  hostRdata
);
  seqStrobe_t    strobe;
  logic          enable, busy, overrun;
  logic [PW-1:0] period;
  logic [BW-1:0] pendBank, activeBank;
  logic [2*DW-1:0] engInFlat, dacFlat;

  loop_seq_ctrl #(.DW(DW), .PW(PW), .BW(BW), .RST_PERIOD(RST_PERIOD)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .engDone(engDone), .strobe(strobe),
    .enable(enable), .period(period), .pendBank(pendBank),
    .activeBank(activeBank), .busy(busy), .overrun(overrun),
    .engStart(engStart)
  );

  loop_seq_dpath #(.DW(DW), .PW(PW), .BW(BW), .NCH(2), .NBANK(NBANK),
                   .NCOEF(NCOEF), .NSTATE(NSTATE)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .adcValid(adcValid),
    .adcFlat({adc1In, adc0In}), .resFlat({engOut1, engOut0}),
    .engInFlat(engInFlat), .dacFlat(dacFlat), .activeBank(activeBank),
    .engCoefIdx(engCoefIdx), .engCoefData(engCoefData),
    .engStateWe(engStateWe), .engStateIdx(engStateIdx),
    .engStateData(engStateData), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .enable(enable), .period(period),
    .pendBank(pendBank), .busy(busy), .overrun(overrun),
    .hostRdata(hostRdata)
  );

  assign engIn0  = engInFlat[DW-1:0];
  assign engIn1  = engInFlat[2*DW-1:DW];
  assign dac0Out = dacFlat[DW-1:0];
  assign dac1Out = dacFlat[2*DW-1:DW];
  assign engBank = activeBank;
endmodule

// File: rtl/loop_seq_chk.sv
module loop_seq_chk #(
  parameter int DW = 16,
  parameter int BW = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          engStart,
  input logic          engDone,
  input logic          busy,
  input logic          overrun,
  input logic [BW-1:0] engBank,
  input logic [DW-1:0] engIn0,
  input logic [DW-1:0] engIn1,
  input logic [DW-1:0] dac0Out,
  input logic [DW-1:0] dac1Out,
  input logic [DW-1:0] engOut0,
  input logic [DW-1:0] engOut1
);
  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    engStart |=> !engStart);

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    engStart |-> busy);

  assert_engin_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !engStart |-> ($stable(engIn0) && $stable(engIn1)));

  assert_dac_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && engDone) |=> (dac0Out == $past(engOut0) && dac1Out == $past(engOut1) && !busy));

  assert_dac_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && engDone) |=> ($stable(dac0Out) && $stable(dac1Out)));

  assert_overrun_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(busy));

  assert_bank_at_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !engStart |-> $stable(engBank));
endmodule

bind loop_seq loop_seq_chk #(.DW(DW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .engStart(engStart), .engDone(engDone),
  .busy(busy), .overrun(overrun), .engBank(engBank), .engIn0(engIn0),
  .engIn1(engIn1), .dac0Out(dac0Out), .dac1Out(dac1Out),
  .engOut0(engOut0), .engOut1(engOut1)
);

// File: tb/loop_seq_bench.sv
`timescale 1ns/1ps
module loop_seq_bench;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adcValid = 1'b0;
  logic [15:0] adc0 = '0, adc1 = '0;
  logic [15:0] dac0Out, dac1Out, engIn0, engIn1, engCoefData, hostRdata;
  logic engStart;
  logic [0:0] engBank;
  logic [2:0] engCoefIdx;
  logic engDone;
  logic [15:0] engOut0, engOut1;
  logic engStateWe;
  logic [2:0] engStateIdx;
  logic [15:0] engStateData;
  logic hWe = 1'b0;
  logic [7:0] hAddr = 8'h03;
  logic [15:0] hWd = '0;
  logic forceDone = 1'b0;
  int stubIdx = 3;
  int stubLat = 3;
  bit adcOn = 1'b0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #(HALF) clk = ~clk;

  loop_seq u_loop_seq (
    .clk(clk), .rst_n(rst_n), .adcValid(adcValid), .adc0In(adc0), .adc1In(adc1),
    .dac0Out(dac0Out), .dac1Out(dac1Out), .engStart(engStart),
    .engIn0(engIn0), .engIn1(engIn1), .engBank(engBank),
    .engCoefIdx(engCoefIdx), .engCoefData(engCoefData), .engDone(engDone),
    .engOut0(engOut0), .engOut1(engOut1), .engStateWe(engStateWe),
    .engStateIdx(engStateIdx), .engStateData(engStateData),
    .hostWe(hWe), .hostAddr(hAddr), .hostWdata(hWd), .hostRdata(hostRdata)
  );

  // ---------------- engine stub ----------------
  logic        stubDone = 1'b0;
  logic [15:0] stubOut0 = '0, stubOut1 = '0, capIn0 = '0, capIn1 = '0, capCoef = '0;
  int          stubLeft = 0;
  bit          stubPend = 1'b0;
  logic        stWe = 1'b0;
  logic [2:0]  stIdx = '0;
  int          stepNum = 0;

  assign engCoefIdx   = 3'(stubIdx);
  assign engDone      = stubDone | forceDone;
  assign engOut0      = forceDone ? 16'hDEAD : stubOut0;
  assign engOut1      = forceDone ? 16'hBEEF : stubOut1;
  assign engStateWe   = stWe;
  assign engStateIdx  = stIdx;
  assign engStateData = stubOut0;

  always @(posedge clk) begin
    stubDone <= 1'b0;
    stWe     <= 1'b0;
    if (!rst_n) begin
      stubPend <= 1'b0;
      stubLeft <= 0;
    end else if (engStart) begin
      stubPend <= 1'b1;
      stubLeft <= stubLat;
      capIn0   <= engIn0;
      capIn1   <= engIn1;
      capCoef  <= engCoefData;
    end else if (stubPend) begin
      if (stubLeft <= 1) begin
        stubDone <= 1'b1;
        stubPend <= 1'b0;
        stubOut0 <= capIn0 + capCoef;
        stubOut1 <= capIn1 ^ 16'h5A5A;
        stWe     <= 1'b1;
        stIdx    <= 3'(stepNum);
        stepNum  <= stepNum + 1;
      end else begin
        stubLeft <= stubLeft - 1;
      end
    end
  end

  // ---------------- input sample driver ----------------
  always @(negedge clk) begin
    #1;
    cyc++;
    adcValid = adcOn && (cyc % 3 != 0);
    adc0 = 16'(cyc * 7 + 1);
    adc1 = 16'(16'h4000 - cyc * 3);
  end

  // ---------------- behavioural reference model ----------------
  int mEn, mPer, mCnt, mBusy, mOvr, mPend, mAct, mStart;
  int mSh0, mSh1, mEng0, mEng1, mDac0, mDac1;
  int mCoef[16];
  int mState[8];

  function automatic int mRead(input int a);
    if (a == 0) return mEn;
    if (a == 1) return mPer;
    if (a == 2) return mPend;
    if (a == 3) return mBusy | (mOvr << 1) | (mAct << 4);
    if (a >= 32 && a < 40) return mState[a - 32];
    if (a >= 64 && a < 80) return mCoef[a - 64];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mEn = 0; mPer = 16; mCnt = 0; mBusy = 0; mOvr = 0; mPend = 0; mAct = 0;
      mStart = 0; mSh0 = 0; mSh1 = 0; mEng0 = 0; mEng1 = 0; mDac0 = 0; mDac1 = 0;
      foreach (mCoef[k]) mCoef[k] = 0;
      foreach (mState[k]) mState[k] = 0;
    end else begin
      bit tt, kick, trig, acc, pub;
      int nBusy;
      kick = hWe && (hAddr == 8'h04);
      tt   = (mEn != 0) && (mCnt + 1 >= mPer);
      trig = tt || kick;
      acc  = trig && (mBusy == 0);
      pub  = engDone && (mBusy != 0);
      if (acc) begin mEng0 = mSh0; mEng1 = mSh1; mAct = mPend; end
      if (pub) begin mDac0 = int'(engOut0); mDac1 = int'(engOut1); end
      nBusy = acc ? 1 : (pub ? 0 : mBusy);
      if (trig && mBusy != 0) mOvr = 1;
      else if (hWe && hAddr == 8'h03) mOvr = 0;
      mBusy = nBusy;
      if (mEn == 0 || tt) mCnt = 0; else mCnt = mCnt + 1;
      if (hWe) begin
        if (hAddr == 8'h00) mEn = int'(hWd[0]);
        if (hAddr == 8'h01) mPer = int'(hWd);
        if (hAddr == 8'h02) mPend = int'(hWd[0]);
        if (hAddr >= 8'h40 && hAddr < 8'h50) mCoef[int'(hAddr) - 64] = int'(hWd);
      end
      if (engStateWe) mState[int'(engStateIdx)] = int'(engStateData);
      if (adcValid) begin mSh0 = int'(adc0); mSh1 = int'(adc1); end
      mStart = acc ? 1 : 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 engStart", int'(engStart), mStart);
      chk("R3 engIn0", int'(engIn0), mEng0);
      chk("R3 engIn1", int'(engIn1), mEng1);
      chk("R4 dac0", int'(dac0Out), mDac0);
      chk("R4 dac1", int'(dac1Out), mDac1);
      chk("R7 engBank", int'(engBank), mAct);
      chk("R8 coef read", int'(engCoefData), mCoef[mAct * 8 + stubIdx]);
      if (hAddr == 8'h03) chk("R6 status", int'(hostRdata), mRead(3));
      else                chk("R9 host read", int'(hostRdata), mRead(int'(hAddr)));
    end
  end

  task automatic hostWrite(input int a, input int d);
    @(negedge clk); #1;
    hWe = 1'b1; hAddr = 8'(a); hWd = 16'(d);
    @(negedge clk); #1;
    hWe = 1'b0; hAddr = 8'h03;
  endtask

  task automatic hostRead(input int a, output int v);
    @(negedge clk); #1;
    hAddr = 8'(a);
    #2 v = int'(hostRdata);
  endtask

  task automatic waitIdle();
    int v;
    for (int i = 0; i < 50; i++) begin
      hostRead(3, v);
      if ((v & 1) == 0) break;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin : stim
    int v, starts;
    logic [15:0] keep0, keep1;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 dac0 reset", int'(dac0Out), 0);
    chk("R1 engStart reset", int'(engStart), 0);
    chk("R1 engBank reset", int'(engBank), 0);
    hostRead(1, v); chk("R1 period reset", v, 16);
    hostRead(3, v); chk("R1 status reset", v, 0);
    hostRead(0, v); chk("R1 enable reset", v, 0);

    // R8 coefficient programming: bank0 = 100+j, bank1 = 200+j
    for (int j = 0; j < 16; j++) hostWrite(64 + j, (j < 8) ? 100 + j : 200 + j);
    hostRead(64 + 9, v); chk("R8 coef readback", v, 209);

    // R2 normal run, long period
    adcOn = 1'b1;
    hostWrite(1, 8);
    hostWrite(0, 1);
    repeat (60) @(negedge clk);
    // R7 bank switch while running
    hostWrite(2, 1);
    repeat (40) @(negedge clk);
    stubIdx = 5;
    repeat (20) @(negedge clk);

    // R6 period shorter than engine latency
    stubLat = 6;
    hostWrite(1, 3);
    repeat (30) @(negedge clk);
    hostRead(3, v); chk("R6 overrun set", (v >> 1) & 1, 1);
    hostWrite(0, 0);
    waitIdle();
    hostWrite(3, 0);
    hostRead(3, v); chk("R6 overrun cleared", (v >> 1) & 1, 0);

    // R2 period zero: trigger every idle cycle
    stubLat = 1;
    hostWrite(1, 0);
    hostWrite(0, 1);
    repeat (30) @(negedge clk);

    // R11 disable stops the timer
    hostWrite(0, 0);
    waitIdle();
    starts = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      starts += int'(engStart);
    end
    chk("R11 no steps while disabled", starts, 0);

    // R7 bank request held until a step; R10 host trigger
    hostWrite(2, 0);
    chk("R7 bank unchanged before step", int'(engBank), 1);
    hostRead(3, v); chk("R7 status bank before step", (v >> 4) & 1, 1);
    hostWrite(4, 1);
    chk("R10 host trigger starts step", int'(engStart), 1);
    chk("R7 bank applied at step", int'(engBank), 0);
    waitIdle();

    // R5 spurious done while idle
    repeat (3) @(negedge clk);
    keep0 = dac0Out; keep1 = dac1Out;
    @(negedge clk); #1 forceDone = 1'b1;
    @(negedge clk); #1 forceDone = 1'b0;
    @(negedge clk);
    chk("R5 dac0 unchanged", int'(dac0Out), int'(keep0));
    chk("R5 dac1 unchanged", int'(dac1Out), int'(keep1));

    // R9 state readback
    for (int i = 0; i < 8; i++) begin
      hostRead(32 + i, v); chk("R9 state window", v, mState[i]);
    end

    // R11 re-enable: first trigger a full period after enable
    hostWrite(1, 5);
    stubLat = 2;
    hostWrite(0, 1);
    repeat (60) @(negedge clk);
    hostWrite(0, 0);
    waitIdle();
    repeat (4) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule